// File: doc/BRIEF.md
# Memory-Resident Block Transfer Channel Controller

This controller moves blocks of words between up to four slow devices and main memory. Each channel's transfer state is kept in memory, not in the controller. Every channel owns a two-word packet at a fixed even address. The first word holds the remaining count as a negative number. The second holds the address of the last word moved. Software loads the packet with the two's complement of the block length and with the start address minus one. After that, each device request moves exactly one word.

When a device asks for service and the controller is free, the controller grants it. The device then presents its packet pointer during that grant cycle. The controller runs three memory transactions in order:

1. A read-modify-write increments the count.
2. A read-modify-write at the pointer plus one increments the address word.
3. A data cycle at the new address moves one word. It writes for an input transfer and reads for an output transfer. An output transfer spends one extra controller cycle presenting the word before strobing it to the device.

When the count increment reaches zero, the word being moved is the last one. The controller then pulses both an overflow line to the device and a completion interrupt.

Top module: `dch_block_channel`

## Requirements
- R1: While reset is held, no grant, acknowledge, strobe, overflow, interrupt or memory request is asserted.
- R2: Requests are granted one at a time with a single-cycle one-hot grant, lowest channel index first, and only to a requesting channel; a channel that keeps requesting is served one word per grant.
- R3: The pointer presented during the grant cycle is stored without increment, and the first memory transaction is a read-modify-write at that address that writes back the word plus one (18-bit wrap), so a packet loaded with -N reads 0 after N words.
- R4: The second transaction is a read-modify-write at pointer plus one that increments the low 15 bits of the address word modulo 2^15 and keeps its upper 3 bits; the new low 15 bits are the data address.
- R5: For an input transfer (dev_in = 1 at grant), the device word is written at the data address, and dev_wack pulses for that channel in the cycle the write is granted, 3 cycles after the grant cycle when memory never stalls.
- R6: For an output transfer (dev_in = 0 at grant), memory is read at the data address, and the word is shown on dev_rdata with dev_rstb pulsing one cycle after the read is granted, 4 cycles after the grant cycle when memory never stalls.
- R7: When the count increment produces zero, dev_ovf and done_irq pulse once for that channel, together with the acknowledge or strobe of that same final word, and never earlier.
- R8: Each word costs exactly three granted memory transactions: two with mem_rmw set and, for an input transfer, one with mem_we set. An output read has neither set, and mem_rmw and mem_we are never both high.
- R9: Once raised, mem_req stays high with mem_addr, mem_we and mem_rmw unchanged until mem_gnt is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dev_req | input | 4 | Per-channel service request, held until granted |
| dev_gnt | output | 4 | One-cycle grant; the device drives dev_ptr and dev_in in this cycle |
| dev_ptr | input | 15 | Packet pointer from the granted device |
| dev_in | input | 1 | 1: device to memory, 0: memory to device |
| dev_wdata | input | 18 | Word from the device for an input transfer |
| dev_wack | output | 4 | Input word accepted |
| dev_rdata | output | 18 | Word read for an output transfer |
| dev_rstb | output | 4 | Output word strobe |
| dev_ovf | output | 4 | Count reached zero; the device should stop requesting |
| done_irq | output | 4 | Block completion interrupt pulse |
| mem_req | output | 1 | Memory transaction request |
| mem_we | output | 1 | Plain write |
| mem_rmw | output | 1 | Read-modify-write: mem_wdata is formed from mem_rdata in the grant cycle |
| mem_addr | output | 15 | Memory address |
| mem_wdata | output | 18 | Write data |
| mem_gnt | input | 1 | Memory grant; mem_rdata is valid in this cycle |
| mem_rdata | input | 18 | Read data |

## Verification
The embedded properties check the following on every cycle:
- the grant is one-hot and goes only to a requester;
- a pending memory request holds still until granted;
- write and read-modify-write never coincide;
- an acknowledge always sits on a granted write;
- a strobe always follows a plain read;
- overflow appears only alongside a word's final handshake.

Other behaviour can only be shown by the bench's sweeps over every channel, direction and block length from one to four, with and without memory stalls. That covers the values left in the count and address words, the data at each incremented address, modulo-2^15 wrap with the upper bits kept, the service order of the priority scheme, the exact latencies, and overflow landing on the last word only.

// File: rtl/dch_pkg.sv
package dch_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_GRANT,
        S_CNT,
        S_ADR,
        S_DIN,
        S_DOUT,
        S_SETL
    } dch_state_e;
endpackage

// File: rtl/dch_prio_arb.sv
module dch_prio_arb #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [IW-1:0] win
);
    always_comb begin
        any = |req;
        win = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) win = IW'(i);
        end
    end
endmodule

// File: rtl/dch_wrap_inc.sv
module dch_wrap_inc #(
    parameter int W   = 18,
    parameter int LOW = 18
) (
    input  logic [W-1:0] val,
    output logic [W-1:0] nxt
);
    generate
        if (LOW >= W) begin : g_full
            assign nxt = val + W'(1);
        end else begin : g_part
            logic [LOW-1:0] lo;
            assign lo  = val[LOW-1:0] + LOW'(1);
            assign nxt = {val[W-1:LOW], lo};
        end
    endgenerate
endmodule

// File: rtl/dch_block_channel.sv
module dch_block_channel
    import dch_pkg::*;
#(
    parameter int NCH = 4,
    parameter int DW  = 18,
    parameter int AW  = 15
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] dev_req,
    output logic [NCH-1:0] dev_gnt,
    input  logic [AW-1:0]  dev_ptr,
    input  logic           dev_in,
    input  logic [DW-1:0]  dev_wdata,
    output logic [NCH-1:0] dev_wack,
    output logic [DW-1:0]  dev_rdata,
    output logic [NCH-1:0] dev_rstb,
    output logic [NCH-1:0] dev_ovf,
    output logic [NCH-1:0] done_irq,
    output logic           mem_req,
    output logic           mem_we,
    output logic           mem_rmw,
    output logic [AW-1:0]  mem_addr,
    output logic [DW-1:0]  mem_wdata,
    input  logic           mem_gnt,
    input  logic [DW-1:0]  mem_rdata
);
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1;

    typedef struct packed {
        dch_state_e     st;
        logic [CHW-1:0] ch;
        logic [AW-1:0]  stor;   // packet pointer, then data address
        logic           dir_in;
        logic           last;   // count wrapped to zero on this word
        logic [DW-1:0]  data;
    } ctl_t;

    ctl_t r_q, r_d;

    logic           arb_any;
    logic [CHW-1:0] arb_win;
    logic [DW-1:0]  cnt_inc;
    logic [DW-1:0]  adr_inc;
    logic [AW-1:0]  ptr_inc;

    dch_prio_arb #(.N(NCH), .IW(CHW)) u_arb (
        .req (dev_req),
        .any (arb_any),
        .win (arb_win)
    );

    dch_wrap_inc #(.W(DW), .LOW(DW)) u_cnt_inc (.val(mem_rdata), .nxt(cnt_inc));
    dch_wrap_inc #(.W(DW), .LOW(AW)) u_adr_inc (.val(mem_rdata), .nxt(adr_inc));
    dch_wrap_inc #(.W(AW), .LOW(AW)) u_ptr_inc (.val(r_q.stor), .nxt(ptr_inc));

    assign dev_rdata = r_q.data;

    always_comb begin
        r_d       = r_q;
        dev_gnt   = '0;
        dev_wack  = '0;
        dev_rstb  = '0;
        dev_ovf   = '0;
        done_irq  = '0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_rmw   = 1'b0;
        mem_addr  = r_q.stor;
        mem_wdata = '0;
        case (r_q.st)
            S_IDLE: begin
                if (arb_any) begin
                    r_d.ch = arb_win;
                    r_d.st = S_GRANT;
                end
            end
            S_GRANT: begin
                dev_gnt[r_q.ch] = 1'b1;
                r_d.stor   = dev_ptr;       // loaded straight, no increment
                r_d.dir_in = dev_in;
                r_d.last   = 1'b0;
                r_d.st     = S_CNT;
            end
            S_CNT: begin
                mem_req   = 1'b1;
                mem_rmw   = 1'b1;
                mem_wdata = cnt_inc;
                if (mem_gnt) begin
                    r_d.last = (cnt_inc == '0);
                    r_d.st   = S_ADR;
                end
            end
            S_ADR: begin
                mem_req   = 1'b1;
                mem_rmw   = 1'b1;
                mem_addr  = ptr_inc;
                mem_wdata = adr_inc;
                if (mem_gnt) begin
                    r_d.stor = adr_inc[AW-1:0];
                    r_d.st   = r_q.dir_in ? S_DIN : S_DOUT;
                end
            end
            S_DIN: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_wdata = dev_wdata;
                if (mem_gnt) begin
                    dev_wack[r_q.ch] = 1'b1;
                    dev_ovf[r_q.ch]  = r_q.last;
                    done_irq[r_q.ch] = r_q.last;
                    r_d.st           = S_IDLE;
                end
            end
            S_DOUT: begin
                mem_req = 1'b1;
                if (mem_gnt) begin
                    r_d.data = mem_rdata;
                    r_d.st   = S_SETL;
                end
            end
            S_SETL: begin
                dev_rstb[r_q.ch] = 1'b1;
                dev_ovf[r_q.ch]  = r_q.last;
                done_irq[r_q.ch] = r_q.last;
                r_d.st           = S_IDLE;
            end
            default: r_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{st: S_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    a_r2_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dev_gnt));

    a_r2_grant_to_requester: assert property (@(posedge clk) disable iff (!rst_n)
        (|dev_gnt) |-> (|(dev_gnt & dev_req)));

    a_r9_request_held: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr)
                                   && $stable(mem_we) && $stable(mem_rmw)));

    a_r8_kind_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !(mem_we && mem_rmw));

    a_r5_ack_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        (|dev_wack) |-> (mem_req && mem_gnt && mem_we));

    a_r6_strobe_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        (|dev_rstb) |-> $past(mem_req && mem_gnt && !mem_we && !mem_rmw));

    a_r7_overflow_on_final: assert property (@(posedge clk) disable iff (!rst_n)
        (|dev_ovf) |-> ((|(dev_ovf & dev_wack)) || (|(dev_ovf & dev_rstb))));
endmodule

// File: tb/test_dch_block_channel.sv
module test_dch_block_channel;
    localparam int NCH = 4;
    localparam int DW  = 18;
    localparam int AW  = 15;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic           rst_n;
    logic [NCH-1:0] dev_req, dev_gnt, dev_wack, dev_rstb, dev_ovf, done_irq;
    logic [AW-1:0]  dev_ptr, mem_addr;
    logic           dev_in, mem_req, mem_we, mem_rmw, mem_gnt;
    logic [DW-1:0]  dev_wdata, dev_rdata, mem_wdata, mem_rdata;

    dch_block_channel #(.NCH(NCH), .DW(DW), .AW(AW)) i_dch_block_channel (
        .clk(clk), .rst_n(rst_n), .dev_req(dev_req), .dev_gnt(dev_gnt),
        .dev_ptr(dev_ptr), .dev_in(dev_in), .dev_wdata(dev_wdata),
        .dev_wack(dev_wack), .dev_rdata(dev_rdata), .dev_rstb(dev_rstb),
        .dev_ovf(dev_ovf), .done_irq(done_irq), .mem_req(mem_req),
        .mem_we(mem_we), .mem_rmw(mem_rmw), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_gnt(mem_gnt), .mem_rdata(mem_rdata)
    );

    int n_cmp = 0;
    int n_bad = 0;

    logic [DW-1:0] mem [256];
    logic [DW-1:0] rx [NCH][8];
    logic [NCH-1:0] req_q = '0;
    logic [NCH-1:0] dir_c = '0;
    int cnt_c [NCH];
    logic [AW-1:0] start_c [NCH];
    logic [2:0] hi_c [NCH];
    int done_n [NCH], lat [NCH], ovf_n [NCH], irq_n [NCH];
    logic last_ok [NCH];
    int glog [16];
    int glen, txn, rmw_n, we_n, hold_bad, cyc, gnt_cyc, act;
    logic clr = 1'b0, stall_en = 1'b0, pend_q = 1'b0;
    logic [AW-1:0] pend_addr;
    logic [7:0] lfsr = 8'h5a;

    function automatic logic [DW-1:0] pin(input int ch, input int k);
        return DW'(ch * 4096 + k * 37 + 5);
    endfunction
    function automatic logic [DW-1:0] pout(input int ch, input int k);
        return DW'(18'o700000 ^ (ch << 8) ^ (k * 11));
    endfunction

    assign dev_req   = req_q;
    assign mem_gnt   = mem_req && (!stall_en || lfsr[0]);
    assign mem_rdata = mem[mem_addr[7:0]];
    assign dev_wdata = pin(act, done_n[act]);

    always_comb begin
        dev_ptr = '0;
        dev_in  = 1'b0;
        for (int i = 0; i < NCH; i++) begin
            if (dev_gnt[i]) begin
                dev_ptr = AW'(8'o30 + 2 * i);
                dev_in  = dir_c[i];
            end
        end
    end

    initial cyc = 0;
    always @(posedge clk) begin
        cyc  <= cyc + 1;
        lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        if (clr) begin
            glen <= 0; txn <= 0; rmw_n <= 0; we_n <= 0; hold_bad <= 0; pend_q <= 1'b0;
            for (int i = 0; i < NCH; i++) begin
                done_n[i] <= 0; lat[i] <= -1; ovf_n[i] <= 0; irq_n[i] <= 0; last_ok[i] <= 1'b0;
            end
        end else begin
            pend_q    <= mem_req && !mem_gnt;
            pend_addr <= mem_addr;
            if (pend_q && (!mem_req || mem_addr != pend_addr)) hold_bad <= hold_bad + 1;
            if (mem_req && mem_gnt) begin
                txn <= txn + 1;
                if (mem_rmw) rmw_n <= rmw_n + 1;
                if (mem_we) we_n <= we_n + 1;
                if (mem_we || mem_rmw) mem[mem_addr[7:0]] <= mem_wdata;
            end
            for (int i = 0; i < NCH; i++) begin
                if (dev_gnt[i]) begin
                    act <= i; gnt_cyc <= cyc;
                    if (glen < 16) begin glog[glen] <= i; glen <= glen + 1; end
                end
                if (dev_wack[i]) begin
                    done_n[i] <= done_n[i] + 1; lat[i] <= cyc - gnt_cyc;
                end
                if (dev_rstb[i]) begin
                    if (done_n[i] < 8) rx[i][done_n[i]] <= dev_rdata;
                    done_n[i] <= done_n[i] + 1; lat[i] <= cyc - gnt_cyc;
                end
                if (dev_ovf[i]) begin
                    ovf_n[i] <= ovf_n[i] + 1;
                    last_ok[i] <= (done_n[i] == cnt_c[i] - 1);
                    req_q[i] <= 1'b0;
                end
                if (done_irq[i]) irq_n[i] <= irq_n[i] + 1;
            end
        end
    end

    task automatic chk(input bit ok, input string rq, input string what,
                       input longint actv, input longint expv);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, actv, expv);
        end
    endtask

    task automatic run_case(input logic [NCH-1:0] en, input bit stall, input bit lat_chk);
        int tot, tin;
        logic [AW-1:0] a;
        bit fin;
        @(negedge clk);
        clr <= 1'b1;
        stall_en <= stall;
        for (int i = 0; i < NCH; i++) begin
            if (en[i]) begin
                mem[8'o30 + 2 * i] <= DW'(-cnt_c[i]);
                mem[8'o31 + 2 * i] <= {hi_c[i], AW'(start_c[i] - 1)};
                for (int k = 0; k < cnt_c[i]; k++) begin
                    a = AW'(start_c[i] + k);
                    mem[a[7:0]] <= dir_c[i] ? '0 : pout(i, k);
                end
            end
        end
        @(negedge clk);
        clr   <= 1'b0;
        req_q <= en;
        fin = 0;
        for (int w = 0; w < 3000 && !fin; w++) begin
            @(negedge clk);
            if (req_q == '0 && !mem_req) fin = 1;
        end
        chk(fin, "R7", "requests released", longint'(req_q), 0);
        repeat (3) @(negedge clk);
        tot = 0; tin = 0;
        for (int i = 0; i < NCH; i++) begin
            if (en[i]) begin
                tot += cnt_c[i];
                if (dir_c[i]) tin += cnt_c[i];
                chk(mem[8'o30 + 2 * i] == '0, "R3", "count word", mem[8'o30 + 2 * i], 0);
                chk(mem[8'o31 + 2 * i] == {hi_c[i], AW'(start_c[i] - 1 + cnt_c[i])}, "R4",
                    "address word", mem[8'o31 + 2 * i], {hi_c[i], AW'(start_c[i] - 1 + cnt_c[i])});
                for (int k = 0; k < cnt_c[i]; k++) begin
                    a = AW'(start_c[i] + k);
                    if (dir_c[i])
                        chk(mem[a[7:0]] == pin(i, k), "R5", "stored word", mem[a[7:0]], pin(i, k));
                    else
                        chk(rx[i][k] == pout(i, k), "R6", "delivered word", rx[i][k], pout(i, k));
                end
                chk(done_n[i] == cnt_c[i], dir_c[i] ? "R5" : "R6", "handshakes", done_n[i], cnt_c[i]);
                chk(ovf_n[i] == 1, "R7", "overflow pulses", ovf_n[i], 1);
                chk(irq_n[i] == 1, "R7", "interrupt pulses", irq_n[i], 1);
                chk(last_ok[i], "R7", "overflow on final word", longint'(last_ok[i]), 1);
                if (lat_chk)
                    chk(lat[i] == (dir_c[i] ? 3 : 4), dir_c[i] ? "R5" : "R6", "latency",
                        lat[i], dir_c[i] ? 3 : 4);
            end
        end
        chk(txn == 3 * tot, "R8", "memory transactions", txn, 3 * tot);
        chk(rmw_n == 2 * tot, "R8", "rmw transactions", rmw_n, 2 * tot);
        chk(we_n == tin, "R8", "write transactions", we_n, tin);
        chk(hold_bad == 0, "R9", "request hold breaks", hold_bad, 0);
    endtask

    initial begin
        #(8 * 150000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        for (int i = 0; i < NCH; i++) begin
            cnt_c[i] = 1; start_c[i] = AW'(8'o100 + 16 * i); hi_c[i] = 3'b000;
        end
        repeat (3) @(negedge clk);
        chk(dev_gnt == '0 && dev_wack == '0 && dev_rstb == '0, "R1", "device side in reset",
            {dev_gnt, dev_wack, dev_rstb}, 0);
        chk(dev_ovf == '0 && done_irq == '0, "R1", "overflow/irq in reset", {dev_ovf, done_irq}, 0);
        chk(!mem_req, "R1", "memory request in reset", mem_req, 0);
        rst_n = 1'b1;

        // single-channel sweep: every channel, both directions, lengths 1..4
        for (int ch = 0; ch < NCH; ch++) begin
            for (int d = 0; d < 2; d++) begin
                for (int n = 1; n <= 4; n++) begin
                    dir_c[ch] <= d[0];
                    cnt_c[ch] = n;
                    start_c[ch] = AW'(8'o100 + 16 * ch + n);
                    hi_c[ch] = 3'(n + ch);
                    run_case(4'(1 << ch), (n % 2) == 1, (n % 2) == 0);
                    chk(glen == n, "R2", "grants for channel", glen, n);
                    for (int j = 0; j < n; j++)
                        chk(glog[j] == ch, "R2", "granted channel", glog[j], ch);
                end
            end
        end

        // all four requesting at once: lowest index is served to completion first
        for (int i = 0; i < NCH; i++) begin
            cnt_c[i] = 2; start_c[i] = AW'(8'o100 + 16 * i); hi_c[i] = 3'b010;
        end
        dir_c <= 4'b0101;
        run_case(4'hF, 1'b0, 1'b1);
        chk(glen == 8, "R2", "total grants", glen, 8);
        for (int j = 0; j < 8; j++)
            chk(glog[j] == j / 2, "R2", "priority order", glog[j], j / 2);

        // address wrap at 2^15 with upper bits kept
        cnt_c[2] = 2; start_c[2] = 15'h7FFF; hi_c[2] = 3'b101;
        dir_c <= 4'b0100;
        run_case(4'b0100, 1'b1, 1'b0);
        cnt_c[1] = 3; start_c[1] = 15'h7FFE; hi_c[1] = 3'b110;
        dir_c <= 4'b0000;
        run_case(4'b0010, 1'b0, 1'b1);

        // mixed lengths and directions under stalls
        cnt_c[0] = 3; cnt_c[1] = 1; cnt_c[2] = 4; cnt_c[3] = 2;
        for (int i = 0; i < NCH; i++) begin
            start_c[i] = AW'(8'o100 + 16 * i); hi_c[i] = 3'(7 - i);
        end
        dir_c <= 4'b1010;
        run_case(4'hF, 1'b1, 1'b0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule